// File: doc/BRIEF.md
# Programmable FIFO Level Flags

This block sits next to a dual-clock FIFO and produces its two watermark flags. An active-low almost-empty flag is resolved in the read-clock domain. An active-low almost-full flag is resolved in the write-clock domain. The FIFO memory and its two pointers are not part of the block. The pointers arrive as binary counts one bit wider than the address, each in its own domain. The block converts each pointer to Gray code and carries it through two flip-flops into the other domain. It then derives the fill level there, compares that level with a programmable threshold and registers the result as the flag.

The two thresholds are held in offset registers: the empty offset and the full offset. A mode input is sampled while the write-side reset is held, and it picks how the offsets get their values:
- from one of two fixed presets;
- from the first two words written on the FIFO write port;
- from a serial bit stream clocked by the write clock.

A configuration-done output tells the FIFO controller when normal writes may start. Until then, both flags stay asserted.

Top module: `fifo_level_flags`

## Requirements
- R1: While the write reset is held, `cfg_done` and `af_n` are 0. While the read reset is held, `ae_n` is 0.
- R2: Mode 2'b01 loads both offsets with PRESET_LO (default 8), and `cfg_done` rises in the first write-clock cycle after reset.
- R3: Mode 2'b10 loads both offsets with PRESET_HI (default 16), and `cfg_done` rises in the first write-clock cycle after reset.
- R4: Once configured and settled, `ae_n` is 0 when the stored count (write pointer minus read pointer, modulo 2·DEPTH) is at or below the empty offset. It is 1 above it.
- R5: Once configured and settled, `af_n` is 0 when the free space (DEPTH minus the stored count) is at or below the full offset. It is 1 above it.
- R6: In mode 2'b00, the first `wr_en` cycle after reset loads `wr_data[AW-1:0]` as the empty offset. The second loads the full offset, and `cfg_done` rises after it. Higher data bits are ignored.
- R7: In mode 2'b11, each write-clock cycle with `ser_en` high shifts in `ser_din`. The stream carries 2·AW bits, most significant bit first, empty offset first and then full offset. `cfg_done` rises after the last bit.
- R8: After `cfg_done` is 1, and in every mode other than the one that uses them, `wr_en`/`wr_data` and `ser_en`/`ser_din` leave the offsets unchanged.
- R9: While configuration is not done, `af_n` and `ae_n` are held at 0.
- R10: The mode input is sampled only while the write reset is held. Changing it afterwards has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst | input | 1 | Write-side synchronous reset, active high |
| rclk | input | 1 | Read-side clock |
| rrst | input | 1 | Read-side synchronous reset, active high |
| cfg_mode | input | 2 | Offset load mode, sampled during wrst |
| wr_ptr | input | AW+1 | Binary write pointer (wclk domain) |
| rd_ptr | input | AW+1 | Binary read pointer (rclk domain) |
| wr_en | input | 1 | FIFO write strobe, used for parallel offset loading |
| wr_data | input | DW | FIFO write data, low AW bits used as an offset |
| ser_en | input | 1 | Serial offset shift enable |
| ser_din | input | 1 | Serial offset data bit |
| cfg_done | output | 1 | Offsets loaded; normal writes may begin |
| ae_n | output | 1 | Almost-empty flag, active low, rclk domain |
| af_n | output | 1 | Almost-full flag, active low, wclk domain |

## Verification
The bench probes each threshold at exactly the offset and at one past it, on both flags. A design with an off-by-one compare would flip one of those two points. It also places pointer pairs across the wrap of the extra pointer bit. A design that computed the level without modular arithmetic would report huge counts there and leave almost-empty released.

Parallel loading is checked with junk in the upper data bits, after only one word has been written, and with a third write after configuration. Each of these catches a design that used too many bits, finished early or kept overwriting the offsets. Serial loading checks bit order and extra shifts after completion. A late change of the mode input must leave the preset in force.

// File: rtl/fifo_flag_pkg.sv
package fifo_flag_pkg;
  typedef enum logic [1:0] {
    CFG_PARALLEL  = 2'b00,
    CFG_PRESET_LO = 2'b01,
    CFG_PRESET_HI = 2'b10,
    CFG_SERIAL    = 2'b11
  } cfg_mode_e;
endpackage

// File: rtl/sync2.sv
// Two-flop synchronizer, vector width as parameter.
module sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gray_xfer.sv
// Moves a binary pointer across clock domains as registered Gray code.
module gray_xfer #(
  parameter int W = 10
) (
  input  logic         src_clk,
  input  logic         src_rst,
  input  logic [W-1:0] src_bin,
  input  logic         dst_clk,
  input  logic         dst_rst,
  output logic [W-1:0] dst_bin
);
  logic [W-1:0] gray_q;
  logic [W-1:0] gray_s;

  always_ff @(posedge src_clk) begin
    if (src_rst) gray_q <= '0;
    else         gray_q <= src_bin ^ (src_bin >> 1);
  end

  sync2 #(.W(W)) u_sync (
    .clk (dst_clk),
    .rst (dst_rst),
    .d   (gray_q),
    .q   (gray_s)
  );

  always_comb begin
    dst_bin[W-1] = gray_s[W-1];
    for (int i = W - 2; i >= 0; i--) begin
      dst_bin[i] = dst_bin[i+1] ^ gray_s[i];
    end
  end
endmodule

// File: rtl/offset_prog.sv
// Offset registers and their three loading modes (write-clock domain).
module offset_prog
  import fifo_flag_pkg::*;
#(
  parameter int AW        = 9,
  parameter int DW        = 36,
  parameter int PRESET_LO = 8,
  parameter int PRESET_HI = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode_in,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          ser_en,
  input  logic          ser_din,
  output logic [AW-1:0] x_off,
  output logic [AW-1:0] y_off,
  output logic          done
);
  localparam int SER_BITS = 2 * AW;
  localparam int CW       = $clog2(SER_BITS + 1);

  cfg_mode_e       mode_q;
  logic            par_second;
  logic [CW-1:0]   bit_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= cfg_mode_e'(mode_in);
      done       <= 1'b0;
      par_second <= 1'b0;
      bit_cnt    <= '0;
      case (cfg_mode_e'(mode_in))
        CFG_PRESET_LO: begin
          x_off <= AW'(PRESET_LO);
          y_off <= AW'(PRESET_LO);
        end
        CFG_PRESET_HI: begin
          x_off <= AW'(PRESET_HI);
          y_off <= AW'(PRESET_HI);
        end
        default: begin
          x_off <= '0;
          y_off <= '0;
        end
      endcase
    end else if (!done) begin
      case (mode_q)
        CFG_PARALLEL: begin
          if (wr_en) begin
            if (!par_second) begin
              x_off      <= wr_data[AW-1:0];
              par_second <= 1'b1;
            end else begin
              y_off <= wr_data[AW-1:0];
              done  <= 1'b1;
            end
          end
        end
        CFG_SERIAL: begin
          if (ser_en) begin
            {x_off, y_off} <= {x_off[AW-2:0], y_off, ser_din};
            bit_cnt        <= bit_cnt + 1'b1;
            if (bit_cnt == CW'(SER_BITS - 1)) done <= 1'b1;
          end
        end
        default: done <= 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/fifo_level_flags.sv
// Almost-empty (read domain) and almost-full (write domain) flag generator.
module fifo_level_flags
  import fifo_flag_pkg::*;
#(
  parameter int DEPTH     = 512,
  parameter int DW        = 36,
  parameter int PRESET_LO = 8,
  parameter int PRESET_HI = 16
) (
  input  logic                   wclk,
  input  logic                   wrst,
  input  logic                   rclk,
  input  logic                   rrst,
  input  logic [1:0]             cfg_mode,
  input  logic [$clog2(DEPTH):0] wr_ptr,
  input  logic [$clog2(DEPTH):0] rd_ptr,
  input  logic                   wr_en,
  input  logic [DW-1:0]          wr_data,
  input  logic                   ser_en,
  input  logic                   ser_din,
  output logic                   cfg_done,
  output logic                   ae_n,
  output logic                   af_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [AW-1:0] x_off;
  logic [AW-1:0] y_off;
  logic [PW-1:0] wptr_r;
  logic [PW-1:0] rptr_w;
  logic          done_r;
  logic [PW-1:0] count_r;
  logic [PW-1:0] count_w;
  logic [PW-1:0] free_w;

  offset_prog #(
    .AW(AW), .DW(DW), .PRESET_LO(PRESET_LO), .PRESET_HI(PRESET_HI)
  ) u_prog (
    .clk     (wclk),
    .rst     (wrst),
    .mode_in (cfg_mode),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ser_en  (ser_en),
    .ser_din (ser_din),
    .x_off   (x_off),
    .y_off   (y_off),
    .done    (cfg_done)
  );

  gray_xfer #(.W(PW)) u_w2r (
    .src_clk (wclk), .src_rst (wrst), .src_bin (wr_ptr),
    .dst_clk (rclk), .dst_rst (rrst), .dst_bin (wptr_r)
  );

  gray_xfer #(.W(PW)) u_r2w (
    .src_clk (rclk), .src_rst (rrst), .src_bin (rd_ptr),
    .dst_clk (wclk), .dst_rst (wrst), .dst_bin (rptr_w)
  );

  sync2 #(.W(1)) u_done_sync (
    .clk (rclk), .rst (rrst), .d (cfg_done), .q (done_r)
  );

  // Offsets are static once done_r is seen, so they are read directly.
  assign count_r = wptr_r - rd_ptr;
  assign count_w = wr_ptr - rptr_w;
  assign free_w  = PW'(DEPTH) - count_w;

  always_ff @(posedge rclk) begin
    if (rrst) ae_n <= 1'b0;
    else      ae_n <= done_r && (count_r > {1'b0, x_off});
  end

  always_ff @(posedge wclk) begin
    if (wrst) af_n <= 1'b0;
    else      af_n <= cfg_done && (free_w > {1'b0, y_off});
  end
endmodule

// File: rtl/fifo_level_flags_chk.sv
module fifo_level_flags_chk #(
  parameter int OW = 9
) (
  input logic          wclk,
  input logic          wrst,
  input logic          rclk,
  input logic          rrst,
  input logic          cfg_done,
  input logic          ae_n,
  input logic          af_n,
  input logic          done_r,
  input logic [OW-1:0] x_off,
  input logic [OW-1:0] y_off
);
  a_r1_wreset_clears: assert property (@(posedge wclk)
    wrst |=> (!cfg_done && !af_n));

  a_r1_rreset_clears: assert property (@(posedge rclk)
    rrst |=> !ae_n);

  a_r9_af_held: assert property (@(posedge wclk) disable iff (wrst)
    !cfg_done |=> !af_n);

  a_r9_ae_held: assert property (@(posedge rclk) disable iff (rrst)
    !done_r |=> !ae_n);

  a_r6_done_sticky: assert property (@(posedge wclk) disable iff (wrst)
    cfg_done |=> cfg_done);

  a_r8_offsets_frozen: assert property (@(posedge wclk) disable iff (wrst)
    cfg_done |=> ($stable(x_off) && $stable(y_off)));
endmodule

bind fifo_level_flags fifo_level_flags_chk #(.OW(AW)) u_chk (
  .wclk     (wclk),
  .wrst     (wrst),
  .rclk     (rclk),
  .rrst     (rrst),
  .cfg_done (cfg_done),
  .ae_n     (ae_n),
  .af_n     (af_n),
  .done_r   (done_r),
  .x_off    (x_off),
  .y_off    (y_off)
);

// File: tb/tb_fifo_level_flags.sv
module tb_fifo_level_flags;
  localparam int DEPTH = 512;
  localparam int AW    = 9;
  localparam int PW    = AW + 1;
  localparam int DW    = 36;

  logic          wclk = 1'b0;
  logic          rclk = 1'b0;
  logic          wrst = 1'b1;
  logic          rrst = 1'b1;
  logic [1:0]    cfg_mode = 2'b01;
  logic [PW-1:0] wr_ptr = '0;
  logic [PW-1:0] rd_ptr = '0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          ser_en = 1'b0;
  logic          ser_din = 1'b0;
  logic          cfg_done, ae_n, af_n;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  fifo_level_flags #(.DEPTH(DEPTH), .DW(DW)) dut (
    .wclk(wclk), .wrst(wrst), .rclk(rclk), .rrst(rrst), .cfg_mode(cfg_mode),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .wr_en(wr_en), .wr_data(wr_data),
    .ser_en(ser_en), .ser_din(ser_din),
    .cfg_done(cfg_done), .ae_n(ae_n), .af_n(af_n)
  );

  // {wr_ptr, rd_ptr, expected ae_n, expected af_n} with both offsets = 8
  localparam int NV = 8;
  localparam logic [2*PW+1:0] VEC [NV] = '{
    {10'd0,   10'd0,    1'b0, 1'b1},
    {10'd8,   10'd0,    1'b0, 1'b1},
    {10'd9,   10'd0,    1'b1, 1'b1},
    {10'd504, 10'd0,    1'b1, 1'b0},
    {10'd503, 10'd0,    1'b1, 1'b1},
    {10'd3,   10'd1019, 1'b0, 1'b1},
    {10'd5,   10'd1020, 1'b1, 1'b1},
    {10'd512, 10'd0,    1'b1, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge wclk);
    wrst = 1'b1; rrst = 1'b1; cfg_mode = m;
    wr_ptr = '0; rd_ptr = '0; wr_en = 1'b0; ser_en = 1'b0;
    repeat (6) @(negedge wclk);
    wrst = 1'b0; rrst = 1'b0;
  endtask

  task automatic set_ptrs(input int w, input int r);
    @(negedge wclk);
    wr_ptr = PW'(w); rd_ptr = PW'(r);
    #100;
  endtask

  task automatic probe(input string req, input int w, input int r,
                       input logic eae, input logic eaf);
    set_ptrs(w, r);
    chk(req, {31'd0, ae_n}, {31'd0, eae});
    chk(req, {31'd0, af_n}, {31'd0, eaf});
  endtask

  initial begin
    #500us;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (4) @(negedge wclk);
    chk("R1 cfg_done", {31'd0, cfg_done}, 32'd0);
    chk("R1 af_n", {31'd0, af_n}, 32'd0);
    chk("R1 ae_n", {31'd0, ae_n}, 32'd0);

    // R2, R4, R5: preset low, table walk
    do_reset(2'b01);
    @(negedge wclk);
    chk("R2 cfg_done", {31'd0, cfg_done}, 32'd1);
    for (int i = 0; i < NV; i++) begin
      probe("R4/R5 vector", int'(VEC[i][2*PW+1:PW+2]), int'(VEC[i][PW+1:2]),
            VEC[i][1], VEC[i][0]);
    end

    // R8: writes and serial bits in preset mode leave offsets alone
    @(negedge wclk);
    wr_en = 1'b1; wr_data = 36'd200; ser_en = 1'b1; ser_din = 1'b1;
    repeat (20) @(negedge wclk);
    wr_en = 1'b0; ser_en = 1'b0;
    probe("R8 preset ignores loads", 9, 0, 1'b1, 1'b1);

    // R10: mode change after reset has no effect
    do_reset(2'b01);
    cfg_mode = 2'b10;
    probe("R10 mode latched", 9, 0, 1'b1, 1'b1);
    probe("R10 mode latched af", 503, 0, 1'b1, 1'b1);

    // R3: preset high
    do_reset(2'b10);
    @(negedge wclk);
    chk("R3 cfg_done", {31'd0, cfg_done}, 32'd1);
    probe("R3 ae at 16", 16, 0, 1'b0, 1'b1);
    probe("R3 ae at 17", 17, 0, 1'b1, 1'b1);
    probe("R3 af free 16", 496, 0, 1'b1, 1'b0);
    probe("R3 af free 17", 495, 0, 1'b1, 1'b1);

    // R6, R9: parallel load, junk in upper bits
    do_reset(2'b00);
    @(negedge wclk);
    wr_en = 1'b1; wr_data = {27'h2A5A5A5, 9'd3};
    @(negedge wclk);
    wr_en = 1'b0;
    set_ptrs(200, 0);
    chk("R6 not done after one word", {31'd0, cfg_done}, 32'd0);
    chk("R9 af held", {31'd0, af_n}, 32'd0);
    chk("R9 ae held", {31'd0, ae_n}, 32'd0);
    @(negedge wclk);
    wr_en = 1'b1; wr_data = {27'h7FFFFFF, 9'd5};
    @(negedge wclk);
    wr_en = 1'b0;
    chk("R6 done after two words", {31'd0, cfg_done}, 32'd1);
    probe("R6 ae at 3", 3, 0, 1'b0, 1'b1);
    probe("R6 ae at 4", 4, 0, 1'b1, 1'b1);
    probe("R6 af free 5", 507, 0, 1'b1, 1'b0);
    probe("R6 af free 6", 506, 0, 1'b1, 1'b1);
    // R8: third write after done is ignored
    @(negedge wclk);
    wr_en = 1'b1; wr_data = 36'd200;
    @(negedge wclk);
    wr_en = 1'b0;
    probe("R8 extra write ignored", 4, 0, 1'b1, 1'b1);

    // R7: serial load X=20, Y=30, MSB first, X then Y
    do_reset(2'b11);
    begin
      logic [2*AW-1:0] stream;
      stream = {9'd20, 9'd30};
      for (int b = 2 * AW - 1; b >= 0; b--) begin
        @(negedge wclk);
        ser_en = 1'b1; ser_din = stream[b];
        if (b == 1) chk("R7 not done before last bit", {31'd0, cfg_done}, 32'd0);
      end
      @(negedge wclk);
      ser_en = 1'b0;
    end
    chk("R7 done", {31'd0, cfg_done}, 32'd1);
    probe("R7 ae at 20", 20, 0, 1'b0, 1'b1);
    probe("R7 ae at 21", 21, 0, 1'b1, 1'b1);
    probe("R7 af free 30", 482, 0, 1'b1, 1'b0);
    probe("R7 af free 31", 481, 0, 1'b1, 1'b1);
    // R8: further serial bits ignored
    @(negedge wclk);
    ser_en = 1'b1; ser_din = 1'b1;
    repeat (20) @(negedge wclk);
    ser_en = 1'b0;
    probe("R8 extra serial ignored", 21, 0, 1'b1, 1'b1);

    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule